// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Nine-Bit Option

This block is a full-duplex asynchronous serial transceiver with a small byte-wide register port. Software or a host engine writes a byte to the data address to send it. The same address, when read, returns the most recently received character. The transmit and receive data registers are separate storage behind that one address. A single 8-bit divisor sets the bit rate. Each bit time lasts 16 × (divisor + 1) system clocks, and the receiver takes 16 samples per bit.

Transmission is double buffered. A byte waits in a holding register while the previous frame shifts out, and the buffer-empty status bit rises when the held byte moves into the shifter. The receiver ignores any falling edge that does not hold low through the middle of the start bit. It decides every bit by a two-of-three vote of the samples at the centre of the bit. When the nine-bit option is on, the extra transmit bit comes from a control bit and the extra received bit appears in a status bit.

Top module: `uart9_core`

## Requirements
- R1: After reset, txd is 1, the divisor reads 0, the control register reads 0, and status reads 0x01: bit0 (transmit buffer empty) is 1 and bit1 (receive done), bit2 (framing error) and bit3 (received ninth bit) are 0.
- R2: A transmitted frame is a 0 start bit, then the data bits with the least significant bit first, then one 1 stop bit. Each bit lasts 16 × (divisor + 1) clocks.
- R3: With control bit0 (nine-bit mode) set, the frame carries nine data bits, and the ninth is control bit1 as it stands when the frame starts. This makes 11 bits on the line, against 10 in eight-bit mode.
- R4: A write to address 0 fills the transmit holding register and clears status bit0. Status bit0 returns to 1 when the held byte moves into the shifter. A byte written while a frame is in flight follows that frame unchanged.
- R5: A received frame sets status bit1. Address 0 then reads the received byte, least significant bit first on the line. A read of address 0 clears status bit1.
- R6: In nine-bit mode the receiver takes nine data bits and places the ninth in status bit3.
- R7: Status bit2 is set by a frame whose stop bit is decided 0, and it is cleared by a frame whose stop bit is decided 1.
- R8: A low pulse on rxd that does not cover samples 8 to 10 of the start bit does not start reception. Status bit1 stays 0, and the next proper frame is received correctly.
- R9: The divisor at address 3 reads back its written value, and a new divisor changes the bit time of both directions.
- R10: A write to address 0 does not alter the received byte that a read of address 0 returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0 data, 1 status, 2 control, 3 divisor |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; clears receive done on address 0 |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, idle high |

## Verification
The transmitter is tried with alternating patterns (0xA5, 0x96), a nibble pattern (0x0F) and nine-bit frames whose extra bit is 1 and then 0. An error in bit order, in the ninth bit source or in the bit length shows up as a wrong captured frame. Two bytes written back to back test the holding register and the timing of the empty flag. The receiver gets clean frames, a frame with a zero stop bit followed by a good frame, and a short low glitch followed by a good frame. These separate the setting and clearing of the framing error and the rejection of the start bit. A second divisor, used in both directions, shows that the bit time follows the register rather than a fixed rate.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
    localparam int OVS_W = 4;   // 16 samples per bit

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;
    localparam logic [1:0] ADDR_DIV  = 2'd3;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;
endpackage

// File: rtl/uart9_baud.sv
module uart9_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             restart_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } baud_t;

    baud_t d, q;

    always_comb begin
        d      = q;
        d.tick = 1'b0;
        if (restart_i) begin
            d.cnt = '0;
        end else if (q.cnt == div_i) begin
            d.cnt  = '0;
            d.tick = 1'b1;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick_o = q.tick;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_i |=> q.cnt <= div_i || $past(div_i) != div_i); // R9
endmodule

// File: rtl/uart9_tx.sv
module uart9_tx
    import uart9_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              nine_i,
    input  logic              bit8_i,
    output logic              txd_o,
    output logic              empty_o
);
    localparam int FRAME_W = DATA_W + 3;
    localparam int LEFT_W  = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [DATA_W-1:0]  hold;
        logic               full;
        logic               busy;
        logic [FRAME_W-1:0] shreg;
        logic [LEFT_W-1:0]  left;
        logic [OVS_W-1:0]   sub;
    } tx_t;

    tx_t d, q;

    always_comb begin
        d = q;
        if (q.busy && tick_i) begin
            d.sub = q.sub + 1'b1;
            if (&q.sub) begin
                d.shreg = {1'b1, q.shreg[FRAME_W-1:1]};
                d.left  = q.left - 1'b1;
                if (q.left == LEFT_W'(1)) d.busy = 1'b0;
            end
        end
        if (!q.busy && q.full) begin
            d.shreg = {1'b1, (nine_i ? bit8_i : 1'b1), q.hold, 1'b0};
            d.left  = nine_i ? LEFT_W'(FRAME_W) : LEFT_W'(FRAME_W - 1);
            d.sub   = '0;
            d.busy  = 1'b1;
            d.full  = 1'b0;
        end
        if (wr_i) begin
            d.hold = wdata_i;
            d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign txd_o   = q.busy ? q.shreg[0] : 1'b1;
    assign empty_o = !q.full;

    AST_EMPTY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.full) |-> q.busy); // R4
    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> !txd_o); // R2
endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
    import uart9_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rxd_i,
    input  logic              nine_i,
    output logic              frame_o,
    output logic [DATA_W-1:0] data_o,
    output logic              bit8_o,
    output logic              stop_o
);
    localparam int CNT_W = $clog2(DATA_W + 2);

    typedef struct packed {
        rx_state_e         state;
        logic [OVS_W-1:0]  sub;
        logic              s0;
        logic              s1;
        logic [DATA_W:0]   shreg;
        logic [CNT_W-1:0]  nbit;
        logic              done;
        logic [DATA_W-1:0] data;
        logic              bit8;
        logic              stop;
    } rx_t;

    rx_t  d, q;
    logic vote;

    assign vote = (q.s0 & q.s1) | (q.s0 & rxd_i) | (q.s1 & rxd_i);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (tick_i) begin
            if (q.state == RX_IDLE) begin
                if (!rxd_i) begin
                    d.state = RX_START;
                    d.sub   = OVS_W'(1);
                end
            end else begin
                d.sub = q.sub + 1'b1;
                if (q.sub == OVS_W'(7)) d.s0 = rxd_i;
                if (q.sub == OVS_W'(8)) d.s1 = rxd_i;
                if (q.sub == OVS_W'(9)) begin
                    case (q.state)
                        RX_START: if (vote) d.state = RX_IDLE;
                        RX_DATA:  d.shreg = {vote, q.shreg[DATA_W:1]};
                        default: begin
                            d.done  = 1'b1;
                            d.stop  = vote;
                            d.data  = nine_i ? q.shreg[DATA_W-1:0] : q.shreg[DATA_W:1];
                            d.bit8  = nine_i & q.shreg[DATA_W];
                            d.state = RX_IDLE;
                        end
                    endcase
                end
                if (&q.sub) begin
                    if (q.state == RX_START) begin
                        d.state = RX_DATA;
                        d.nbit  = '0;
                    end else if (q.state == RX_DATA) begin
                        d.nbit = q.nbit + 1'b1;
                        if (q.nbit == (nine_i ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1)))
                            d.state = RX_STOP;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= RX_IDLE;
            q.stop  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign frame_o = q.done;
    assign data_o  = q.data;
    assign bit8_o  = q.bit8;
    assign stop_o  = q.stop;

    AST_REJECT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == RX_START && tick_i && q.sub == OVS_W'(9) && vote)
        |=> (q.state == RX_IDLE && !q.done)); // R8
    AST_FRAME_ENDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> q.state == RX_IDLE); // R5
endmodule

// File: rtl/uart9_core.sv
module uart9_core
    import uart9_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              rxd,
    output logic              txd
);
    typedef struct packed {
        logic [1:0]        sync;
        logic              nine;
        logic              txb8;
        logic [DATA_W-1:0] div;
        logic              rx_done;
    } core_t;

    core_t             d, q;
    logic              tick, tx_empty, rx_frame, rx_bit8, rx_stop;
    logic [DATA_W-1:0] rx_data;
    logic              wr_data, wr_div;

    assign wr_data = reg_wr && reg_addr == ADDR_DATA;
    assign wr_div  = reg_wr && reg_addr == ADDR_DIV;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], rxd};
        if (reg_wr && reg_addr == ADDR_CTRL) begin
            d.nine = reg_wdata[0];
            d.txb8 = reg_wdata[1];
        end
        if (wr_div) d.div = reg_wdata;
        if (reg_rd && reg_addr == ADDR_DATA) d.rx_done = 1'b0;
        if (rx_frame) d.rx_done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.sync <= 2'b11;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_DATA: reg_rdata = rx_data;
            ADDR_STAT: reg_rdata = {{(DATA_W-4){1'b0}}, rx_bit8, !rx_stop, q.rx_done, tx_empty};
            ADDR_CTRL: reg_rdata = {{(DATA_W-2){1'b0}}, q.txb8, q.nine};
            default:   reg_rdata = q.div;
        endcase
    end

    uart9_baud #(.DIV_W(DATA_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div_i(q.div), .restart_i(wr_div), .tick_o(tick)
    );

    uart9_tx #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_i(wr_data), .wdata_i(reg_wdata),
        .nine_i(q.nine), .bit8_i(q.txb8), .txd_o(txd), .empty_o(tx_empty)
    );

    uart9_rx #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .rxd_i(q.sync[1]), .nine_i(q.nine),
        .frame_o(rx_frame), .data_o(rx_data), .bit8_o(rx_bit8), .stop_o(rx_stop)
    );

    AST_FE_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_stop) |-> rx_frame); // R7
    AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame |=> q.rx_done); // R5
    AST_RXDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && !rx_frame) |=> $stable(rx_data)); // R10
endmodule

// File: tb/uart9_core_test.sv
module uart9_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       rxd = 1'b1;
    logic       txd;

    int checks = 0;
    int fails = 0;
    int bitp = 32;

    always #2.5 clk = ~clk;

    uart9_core uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rxd(rxd), .txd(txd)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic capture(input int n, output logic [10:0] bits);
        bits = '1;
        while (txd !== 1'b0) @(negedge clk);
        repeat (bitp / 2) @(negedge clk);
        bits[0] = txd;
        for (int i = 1; i < n; i++) begin
            repeat (bitp) @(negedge clk);
            bits[i] = txd;
        end
    endtask

    task automatic send(input logic [8:0] v, input int nbits, input logic stopv);
        rxd = 1'b0;
        repeat (bitp) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            rxd = v[i];
            repeat (bitp) @(negedge clk);
        end
        rxd = stopv;
        repeat (bitp) @(negedge clk);
        rxd = 1'b1;
        repeat (bitp) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 txd idle", {15'd0, txd}, 16'd1);
        rd(2'd1, v); check("R1 status", {8'd0, v}, 16'h01);
        rd(2'd3, v); check("R1 divisor", {8'd0, v}, 16'h00);
        rd(2'd2, v); check("R1 control", {8'd0, v}, 16'h00);
    endtask

    task automatic t_divisor(input logic [7:0] dv);
        logic [7:0] v;
        wr(2'd3, dv);
        bitp = 16 * (dv + 1);
        rd(2'd3, v); check("R9 divisor readback", {8'd0, v}, {8'd0, dv});
    endtask

    task automatic t_tx8();
        logic [7:0] v;
        logic [10:0] b;
        wr(2'd0, 8'hA5);
        rd(2'd1, v); check("R4 empty cleared by write", {15'd0, v[0]}, 16'd0);
        rd(2'd1, v); check("R4 empty set on load", {15'd0, v[0]}, 16'd1);
        capture(10, b);
        check("R2 frame 8-bit", {6'd0, b[9:0]}, {6'd0, 1'b1, 8'hA5, 1'b0});
    endtask

    task automatic t_double();
        logic [7:0] v;
        logic [10:0] b;
        wr(2'd0, 8'h96);
        repeat (3) @(negedge clk);
        wr(2'd0, 8'h3C);
        rd(2'd1, v); check("R4 held byte waits", {15'd0, v[0]}, 16'd0);
        capture(10, b);
        check("R4 first frame", {6'd0, b[9:0]}, {6'd0, 1'b1, 8'h96, 1'b0});
        capture(10, b);
        check("R4 second frame", {6'd0, b[9:0]}, {6'd0, 1'b1, 8'h3C, 1'b0});
    endtask

    task automatic t_tx9(input logic b8, input logic [7:0] dat);
        logic [10:0] b;
        wr(2'd2, {6'd0, b8, 1'b1});
        wr(2'd0, dat);
        capture(11, b);
        check("R3 nine-bit frame", {5'd0, b}, {5'd0, 1'b1, b8, dat, 1'b0});
        repeat (bitp) @(negedge clk);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_rx8(input logic [7:0] dat);
        logic [7:0] v;
        send({1'b0, dat}, 8, 1'b1);
        rd(2'd1, v); check("R5 done set", {14'd0, v[2:1]}, 16'b01);
        rd(2'd0, v); check("R5 received byte", {8'd0, v}, {8'd0, dat});
        rd(2'd1, v); check("R5 done cleared by read", {15'd0, v[1]}, 16'd0);
    endtask

    task automatic t_rx9();
        logic [7:0] v;
        wr(2'd2, 8'h01);
        send(9'h181, 9, 1'b1);
        rd(2'd1, v); check("R6 ninth bit status", {15'd0, v[3]}, 16'd1);
        rd(2'd0, v); check("R6 nine-bit data", {8'd0, v}, 16'h81);
        send(9'h07E, 9, 1'b1);
        rd(2'd1, v); check("R6 ninth bit zero", {15'd0, v[3]}, 16'd0);
        rd(2'd0, v); check("R6 nine-bit data 2", {8'd0, v}, 16'h7E);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_frame_err();
        logic [7:0] v;
        send(9'h0C3, 8, 1'b0);
        rd(2'd1, v); check("R7 framing error set", {15'd0, v[2]}, 16'd1);
        rd(2'd0, v);
        send(9'h024, 8, 1'b1);
        rd(2'd1, v); check("R7 framing error cleared", {15'd0, v[2]}, 16'd0);
        rd(2'd0, v); check("R7 good byte after error", {8'd0, v}, 16'h24);
    endtask

    task automatic t_glitch();
        logic [7:0] v;
        rxd = 1'b0;
        repeat (6) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * bitp) @(negedge clk);
        rd(2'd1, v); check("R8 glitch ignored", {15'd0, v[1]}, 16'd0);
        send(9'h033, 8, 1'b1);
        rd(2'd0, v); check("R8 frame after glitch", {8'd0, v}, 16'h33);
    endtask

    task automatic t_shared();
        logic [7:0] v;
        logic [10:0] b;
        send(9'h05A, 8, 1'b1);
        wr(2'd0, 8'h11);
        rd(2'd0, v); check("R10 rx byte kept", {8'd0, v}, 16'h5A);
        capture(10, b);
        check("R10 tx byte sent", {6'd0, b[9:0]}, {6'd0, 1'b1, 8'h11, 1'b0});
        repeat (bitp) @(negedge clk);
    endtask

    task automatic t_rate();
        logic [10:0] b;
        t_divisor(8'd3);
        wr(2'd0, 8'h0F);
        capture(10, b);
        check("R9 tx at new rate", {6'd0, b[9:0]}, {6'd0, 1'b1, 8'h0F, 1'b0});
        repeat (bitp) @(negedge clk);
        t_rx8(8'hE1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_divisor(8'd1);
        t_tx8();
        repeat (bitp) @(negedge clk);
        t_double();
        repeat (bitp) @(negedge clk);
        t_tx9(1'b1, 8'h3C);
        t_tx9(1'b0, 8'hFF);
        t_rx8(8'h5A);
        t_rx9();
        t_frame_err();
        t_glitch();
        t_shared();
        t_rate();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule